// File: doc/BRIEF.md
# Two-Page Next-Hop Table

This block holds a forwarding table of next-hop entries in two equal pages. One page is active and serves lookups. The other is a shadow page that a control agent fills with a complete new table while lookups carry on. Each entry holds an outgoing interface number, the destination MAC address to put on frames for that interface, and an entry-valid flag. A lookup of an entry without a valid next-hop returns a discard indication.

When the shadow page is complete, one commit strobe swaps the roles of the two pages. The swap takes effect one cycle later and needs no further writes. A lookup always reads one whole page: either the old table or the new one, never a mix. A lookup accepted before the swap edge reads the old page, even when its result comes back after the swap. At the swap edge every entry of the page that has just become the shadow is marked invalid, so each new table starts out empty.

Lookups use a two-stage pipelined request/response port with valid/ready handshakes on both sides. Table writes use a simple strobe port whose ready signal drops for the one cycle in which a swap is pending.

Top module: `nh_page_table`

## Requirements
- R1: For the first cycle after reset and onward until the first swap, `active_page` reads 0. Every entry of both pages is invalid, so every lookup returns `lk_rsp_drop`=1.
- R2: With `lk_rsp_ready` held high, a request accepted in cycle c (`lk_req_valid` and `lk_req_ready` both high) has `lk_rsp_valid` low in cycle c+1 and high in cycle c+2. The response carries the interface and MAC of the addressed entry. Back-to-back requests are accepted one per cycle.
- R3: A write accepted in a cycle goes to entry `wr_idx` of the page that is not active in that cycle. Lookup results from the active page are not changed by it.
- R4: If `commit` is high in cycle n while no swap is pending, the swap is pending in cycle n+1 and `active_page` shows the other page from cycle n+2 on. `active_page` changes at no other time.
- R5: `wr_ready` is low only in a cycle in which a swap is pending. A write presented in that cycle is not accepted.
- R6: A lookup accepted in cycle n or n+1 of R4 reads the old page. A lookup accepted from cycle n+2 on reads the new page.
- R7: A lookup of an entry written with `wr_entry_ok`=0, or never written since the page was last cleared, returns `lk_rsp_drop`=1 with `lk_rsp_ifc` and `lk_rsp_mac` both zero. A valid entry returns `lk_rsp_drop`=0.
- R8: At the swap edge, every entry of the page that stops being active becomes invalid.
- R9: While `lk_rsp_valid` is high and `lk_rsp_ready` is low, the response outputs hold their values into the next cycle. Responses come back in request order, with none lost and none repeated.
- R10: A `commit` asserted in the cycle in which a swap is already pending is ignored. It produces exactly one page change.
- R11: A write accepted in the same cycle as `commit` is part of the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req_valid | input | 1 | Lookup request present |
| lk_req_ready | output | 1 | Lookup request can be accepted |
| lk_req_idx | input | IDX_W | Table index to look up |
| lk_rsp_valid | output | 1 | Lookup response present |
| lk_rsp_ready | input | 1 | Consumer takes the response |
| lk_rsp_ifc | output | IF_W | Outgoing interface number (0 on discard) |
| lk_rsp_mac | output | MAC_W | Destination MAC to prepend (0 on discard) |
| lk_rsp_drop | output | 1 | 1: entry has no valid next-hop, discard |
| wr_en | input | 1 | Table write strobe |
| wr_ready | output | 1 | Write can be accepted (low while a swap is pending) |
| wr_idx | input | IDX_W | Shadow-page entry to write |
| wr_ifc | input | IF_W | Interface number to store |
| wr_mac | input | MAC_W | MAC address to store |
| wr_entry_ok | input | 1 | Entry-valid flag to store |
| commit | input | 1 | Swap strobe: make the shadow page active |
| active_page | output | 1 | Page currently serving lookups (0 or 1) |

## Verification
The bench builds the block with IDX_W=3, IF_W=4 and MAC_W=48. With only eight entries per page, it can write every entry of the shadow page in each of several table generations and then read back every index of the new active page. Each entry's contents and valid flag are computed arithmetically from its index and the generation number. The small depth also lets the bench place lookups in the commit cycle, the pending cycle and the first cycle after the swap. It checks both a full rebuild and a partial rebuild of the table, under both a free-running consumer and a periodically stalled one.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

  // Swap sequencer states
  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_SWAP = 1'b1
  } ctl_e;

endpackage

// File: rtl/fpt_page_mem.sv
// Two-page data store: one synchronous write port, one registered read
// port; no reset on the array so it maps onto block RAM.
module fpt_page_mem #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W:0]    raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WORDS = 2 * DEPTH;

  logic [DATA_W-1:0] store [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

  // Writes target the shadow page, reads the active one: never the same word
  AST_RW_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (we && re) |-> (waddr != raddr)); // R3

endmodule

// File: rtl/fpt_valid_bits.sv
// Entry-valid flags for both pages, held in flops so that reset and the
// page-wide clear at a swap take a single cycle.
module fpt_valid_bits #(
  parameter int IDX_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [IDX_W:0] waddr,
  input  logic           wbit,
  input  logic           clr_en,
  input  logic           clr_page,
  input  logic           re,
  input  logic [IDX_W:0] raddr,
  output logic           rbit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WORDS = 2 * DEPTH;

  logic [WORDS-1:0] bits_q;
  logic [WORDS-1:0] bits_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_flag
    localparam bit HALF = (g >= DEPTH);
    logic hit_clr;
    logic hit_wr;
    assign hit_clr  = clr_en && (clr_page == HALF);
    assign hit_wr   = we && (waddr == (IDX_W+1)'(g));
    assign bits_d[g] = hit_clr ? 1'b0 : (hit_wr ? wbit : bits_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      rbit   <= 1'b0;
    end else begin
      bits_q <= bits_d;
      if (re) rbit <= bits_q[raddr];
    end
  end

  // After a page clear, the cleared half holds no valid entry
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (($past(clr_page) ? bits_q[WORDS-1:DEPTH] : bits_q[DEPTH-1:0]) == '0)); // R8

endmodule

// File: rtl/fpt_page_ctrl.sv
// Swap sequencer: a commit arms one pending cycle, then the active page flips.
module fpt_page_ctrl
  import fpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic commit,
  output logic active_page,
  output logic swap_now,
  output logic wr_ready
);
  ctl_e st_q;
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CT_IDLE;
      act_q <= 1'b0;
    end else begin
      case (st_q)
        CT_IDLE: if (commit) st_q <= CT_SWAP;
        CT_SWAP: begin
          act_q <= ~act_q;
          st_q  <= CT_IDLE;
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end

  assign active_page = act_q;
  assign swap_now    = (st_q == CT_SWAP);
  assign wr_ready    = (st_q == CT_IDLE);

  AST_RESET_PAGE0: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (active_page == 1'b0)); // R1
  AST_FLIP_ONLY_ON_SWAP: assert property (@(posedge clk) disable iff (rst)
    (active_page != $past(active_page)) |-> $past(swap_now)); // R4
  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (rst)
    (commit && !swap_now) |=> swap_now); // R4
  AST_SWAP_ONCE: assert property (@(posedge clk) disable iff (rst)
    swap_now |=> !swap_now); // R10

endmodule

// File: rtl/fpt_lookup_pipe.sv
// Two-stage lookup pipeline: stage 1 is the memory read register, stage 2
// the response register. Back-pressure stalls both stages in place.
module fpt_lookup_pipe #(
  parameter int IDX_W = 4,
  parameter int IF_W  = 4,
  parameter int MAC_W = 48
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic                  active_page,
  output logic                  rd_en,
  output logic [IDX_W:0]        rd_addr,
  input  logic [IF_W+MAC_W-1:0] rd_data,
  input  logic                  rd_bit,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [IF_W-1:0]       rsp_ifc,
  output logic [MAC_W-1:0]      rsp_mac,
  output logic                  rsp_drop
);
  logic s1_q;
  logic out_go;

  assign out_go    = !rsp_valid || rsp_ready;
  assign req_ready = !s1_q || out_go;
  assign rd_en     = req_ready;
  // Page is bound at acceptance: the read address carries it
  assign rd_addr   = {active_page, req_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ifc   <= '0;
      rsp_mac   <= '0;
      rsp_drop  <= 1'b0;
    end else begin
      if (req_ready) s1_q <= req_valid;
      if (out_go) begin
        rsp_valid <= s1_q;
        rsp_drop  <= !rd_bit;
        rsp_ifc   <= rd_bit ? rd_data[IF_W+MAC_W-1:MAC_W] : '0;
        rsp_mac   <= rd_bit ? rd_data[MAC_W-1:0] : '0;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ifc) &&
                                   $stable(rsp_mac) && $stable(rsp_drop))); // R9
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready && s1_q) |-> !req_ready); // R9

endmodule

// File: rtl/nh_page_table.sv
module nh_page_table #(
  parameter int IDX_W = 4,
  parameter int IF_W  = 4,
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req_valid,
  output logic             lk_req_ready,
  input  logic [IDX_W-1:0] lk_req_idx,
  output logic             lk_rsp_valid,
  input  logic             lk_rsp_ready,
  output logic [IF_W-1:0]  lk_rsp_ifc,
  output logic [MAC_W-1:0] lk_rsp_mac,
  output logic             lk_rsp_drop,
  input  logic             wr_en,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IF_W-1:0]  wr_ifc,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic             wr_entry_ok,
  input  logic             commit,
  output logic             active_page
);
  localparam int DATA_W = IF_W + MAC_W;

  logic              swap_now;
  logic              mem_we;
  logic [IDX_W:0]    mem_waddr;
  logic              rd_en;
  logic [IDX_W:0]    rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_bit;

  fpt_page_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .active_page (active_page),
    .swap_now    (swap_now),
    .wr_ready    (wr_ready)
  );

  assign mem_we    = wr_en && wr_ready;
  assign mem_waddr = {~active_page, wr_idx};

  fpt_page_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata ({wr_ifc, wr_mac}),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Clear the page that stops being active at the swap edge
  fpt_valid_bits #(.IDX_W(IDX_W)) u_vld (
    .clk      (clk),
    .rst      (rst),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wbit     (wr_entry_ok),
    .clr_en   (swap_now),
    .clr_page (active_page),
    .re       (rd_en),
    .raddr    (rd_addr),
    .rbit     (rd_bit)
  );

  fpt_lookup_pipe #(.IDX_W(IDX_W), .IF_W(IF_W), .MAC_W(MAC_W)) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (lk_req_valid),
    .req_ready   (lk_req_ready),
    .req_idx     (lk_req_idx),
    .active_page (active_page),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .rd_bit      (rd_bit),
    .rsp_valid   (lk_rsp_valid),
    .rsp_ready   (lk_rsp_ready),
    .rsp_ifc     (lk_rsp_ifc),
    .rsp_mac     (lk_rsp_mac),
    .rsp_drop    (lk_rsp_drop)
  );

  AST_NO_WRITE_ON_SWAP: assert property (@(posedge clk) disable iff (rst)
    swap_now |-> !mem_we); // R5

endmodule

// File: tb/test_nh_page_table.sv
module test_nh_page_table;
  localparam int IDX_W  = 3;
  localparam int IF_W   = 4;
  localparam int MAC_W  = 48;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int CLK_NS = 10;
  localparam int WD_CYC = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_req_valid = 1'b0;
  logic             lk_req_ready;
  logic [IDX_W-1:0] lk_req_idx = '0;
  logic             lk_rsp_valid;
  logic             lk_rsp_ready = 1'b1;
  logic [IF_W-1:0]  lk_rsp_ifc;
  logic [MAC_W-1:0] lk_rsp_mac;
  logic             lk_rsp_drop;
  logic             wr_en = 1'b0;
  logic             wr_ready;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [IF_W-1:0]  wr_ifc = '0;
  logic [MAC_W-1:0] wr_mac = '0;
  logic             wr_entry_ok = 1'b0;
  logic             commit = 1'b0;
  logic             active_page;

  always #(CLK_NS/2) clk = ~clk;

  nh_page_table #(.IDX_W(IDX_W), .IF_W(IF_W), .MAC_W(MAC_W)) i_nh_page_table (
    .clk(clk), .rst(rst),
    .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready), .lk_req_idx(lk_req_idx),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_ready(lk_rsp_ready),
    .lk_rsp_ifc(lk_rsp_ifc), .lk_rsp_mac(lk_rsp_mac), .lk_rsp_drop(lk_rsp_drop),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_ifc(wr_ifc),
    .wr_mac(wr_mac), .wr_entry_ok(wr_entry_ok), .commit(commit),
    .active_page(active_page)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model of both pages
  logic             m_v [0:1][0:DEPTH-1];
  logic [IF_W-1:0]  m_i [0:1][0:DEPTH-1];
  logic [MAC_W-1:0] m_m [0:1][0:DEPTH-1];
  logic act_m  = 1'b0;
  logic pend_m = 1'b0;

  // Expected response queue
  logic [63:0] e_val [0:1023];
  string       e_tag [0:1023];
  int wp = 0;
  int rp = 0;

  int    cyc_n = 0;
  bit    bp_on = 1'b0;
  bit    last_acc;
  logic  sv_rsp_valid;
  bit    prev_stall = 1'b0;
  logic [63:0] prev_rsp;
  string cur_tag = "R2";

  function automatic logic [IF_W-1:0] f_ifc(int i, int g);
    return IF_W'((i * 5 + g * 3) % 16);
  endfunction
  function automatic logic [MAC_W-1:0] f_mac(int i, int g);
    return {16'h5E00 + 16'(g), 8'(i), 24'(g * 7919 + i * 13)};
  endfunction
  function automatic logic f_ok(int i, int g);
    return ((i + g) % 3) != 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock cycle: drive at the falling edge, sample, then model the rising edge
  task automatic cyc(input bit rv, input int ri, input bit we, input int wi,
                     input int gen, input bit cm);
    logic        rr;
    logic [63:0] got;
    bit          wacc;
    @(negedge clk);
    rr = bp_on ? ((cyc_n % 3) != 1) : 1'b1;
    lk_req_valid = rv;
    lk_req_idx   = IDX_W'(ri);
    lk_rsp_ready = rr;
    wr_en        = we;
    wr_idx       = IDX_W'(wi);
    wr_ifc       = f_ifc(wi, gen);
    wr_mac       = f_mac(wi, gen);
    wr_entry_ok  = f_ok(wi, gen);
    commit       = cm;
    #1;
    got = 64'({lk_rsp_drop, lk_rsp_ifc, lk_rsp_mac});
    if (prev_stall) begin
      chk(lk_rsp_valid === 1'b1, "R9", "valid held under stall", 64'(lk_rsp_valid), 64'd1);
      chk(got === prev_rsp, "R9", "response held under stall", got, prev_rsp);
    end
    chk(active_page === act_m, "R4", "active_page", 64'(active_page), 64'(act_m));
    chk(wr_ready === !pend_m, "R5", "wr_ready", 64'(wr_ready), 64'(!pend_m));
    last_acc = rv && lk_req_ready;
    if (last_acc) begin
      logic v;
      v = m_v[act_m][ri];
      e_val[wp % 1024] = 64'({!v, v ? m_i[act_m][ri] : 4'h0, v ? m_m[act_m][ri] : 48'h0});
      e_tag[wp % 1024] = cur_tag;
      wp++;
    end
    if (lk_rsp_valid && rr) begin
      if (rp == wp) chk(1'b0, "R9", "unexpected response", got, 64'd0);
      else begin
        chk(got === e_val[rp % 1024], e_tag[rp % 1024], "lookup response", got, e_val[rp % 1024]);
        rp++;
      end
    end
    prev_stall   = lk_rsp_valid && !rr;
    prev_rsp     = got;
    sv_rsp_valid = lk_rsp_valid;
    wacc = we && !pend_m;
    @(posedge clk);
    cyc_n++;
    if (wacc) begin
      m_v[!act_m][wi] = f_ok(wi, gen);
      m_i[!act_m][wi] = f_ifc(wi, gen);
      m_m[!act_m][wi] = f_mac(wi, gen);
    end
    if (pend_m) begin
      for (int k = 0; k < DEPTH; k++) m_v[act_m][k] = 1'b0; // R8: old page cleared
      act_m  = !act_m;
      pend_m = 1'b0;
    end else if (cm) begin
      pend_m = 1'b1;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && rp != wp; k++) cyc(0, 0, 0, 0, 0, 0);
    chk(rp == wp, "R9", "all responses returned", 64'(rp), 64'(wp));
  endtask

  task automatic sweep(input string tag);
    cur_tag = tag;
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, i, 0, 0, 0, 0);
      while (!last_acc) cyc(1, i, 0, 0, 0, 0);
    end
    drain();
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < DEPTH; i++) begin
        m_v[p][i] = 1'b0; m_i[p][i] = '0; m_m[p][i] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state and empty tables
    cyc(0, 0, 0, 0, 0, 0);
    chk(sv_rsp_valid === 1'b0, "R1", "no response after reset", 64'(sv_rsp_valid), 64'd0);
    sweep("R1");

    // R2: latency of two cycles from acceptance
    cur_tag = "R2";
    cyc(1, 3, 0, 0, 0, 0);
    chk(last_acc, "R2", "request accepted", 64'(last_acc), 64'd1);
    cyc(0, 0, 0, 0, 0, 0);
    chk(sv_rsp_valid === 1'b0, "R2", "valid low one cycle after accept", 64'(sv_rsp_valid), 64'd0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(sv_rsp_valid === 1'b1, "R2", "valid high two cycles after accept", 64'(sv_rsp_valid), 64'd1);
    drain();

    // R3 R11 R10 R5: full rebuilds with lookups running alongside
    for (int gen = 1; gen <= 4; gen++) begin
      bp_on = (gen % 2) == 0;
      cur_tag = "R3";
      for (int i = 0; i < DEPTH; i++)
        cyc(1, (i * 3) % DEPTH, 1, i, gen, i == DEPTH - 1); // R11: last write with commit
      cur_tag = "R6";
      cyc(1, 5, 1, 0, gen + 50, 1); // R5 held write, R10 ignored commit
      sweep(bp_on ? "R9" : "R11");
    end
    bp_on = 1'b0;

    // R8: partial table, untouched entries must read invalid
    cyc(0, 0, 1, 0, 11, 0);
    cyc(0, 0, 1, 2, 11, 1);
    cyc(0, 0, 0, 0, 0, 0);
    sweep("R8");

    // R6: lookups every cycle across a swap, R7 drop vs valid on one index
    cur_tag = "R6";
    cyc(1, 1, 1, 1, 12, 0);
    cyc(1, 1, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    drain();
    cur_tag = "R7";
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYC);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule